// File: doc/BRIEF.md
# ATAPI DMA Direction Resolver

This block sits inside a bridge between a serial ATA host link and a parallel ATA packet device. When the parallel device raises its DMA request for a packet command, the bridge must already know which way the data moves. For a host-to-device transfer the link layer must send a DMA Activate frame to the host. For a device-to-host transfer it must carry the device's data to the host in Data frames. The block does not read the device task file once DMA request is up, because many devices return a constant such as 0x7F or garbage there. Instead it takes the direction from a bit in the features byte that the host driver writes together with the packet command.

The block keeps a copy of the features value written into the shadow registers. When the PACKET opcode is written to the command register, it resolves the direction and freezes it. A per-device enable says whether the selected device supports the direction bit. When that enable is off, a strap picks the fallback: treat the transfer as a read, or flag it as unsupported so the host can abort or retry in PIO. The block waits for a rising edge of the device DMA request, which passes through an input synchronizer first, and then drives its outputs. A soft reset or COMRESET input clears all pending state.

Top module: `dma_dir_resolver`

## Requirements
- R1: After rst_ni is asserted, every output is 0. One clock edge after soft_rst_i is sampled high, every output is 0. A command resolved before a soft reset has no effect on any later DMA request.
- R2: Only a command write of opcode 0xA0 resolves a packet command. Any other opcode leaves all outputs at 0, and no later DMA request causes any action.
- R3: A PACKET command whose features bit 0 is 0 is a PIO command. pio_o goes to 1 on the clock edge that takes the command write and stays at 1 until the next command write or reset. DMA requests do not affect it and produce no DMA output.
- R4: A DMA packet command (features bit 0 = 1) with the direction bit enabled and features bit 2 = 0 is a write. dma_act_o pulses high for exactly one cycle, SYNC_STAGES+1 clock edges after dmarq_i rises, and data_in_o stays at 0.
- R5: With the direction bit enabled and features bit 2 = 1, the command is a read. data_in_o rises SYNC_STAGES+1 edges after dmarq_i rises. It stays high until SYNC_STAGES+1 edges after dmarq_i falls, and dma_act_o stays at 0.
- R6: With the direction bit disabled for the selected device, the strap decides the outcome. fb_read_i = 1 resolves the command as a read, as in R5. fb_read_i = 0 sets unsupp_o on the DMA request rising edge and holds it until the next command write or reset. The block still returns to idle when the request falls.
- R7: The direction-bit enable is taken from dir_en_i, indexed by dev_sel_i, at the cycle of the command write. Bit n applies to device n.
- R8: The direction is frozen at the PACKET command write, so later features writes do not change it. A new command write before the DMA request clears the old decision and resolves again.
- R9: After the DMA request of a resolved command falls, the block is idle. Further DMA requests produce no output until another PACKET command is written.
- R10: At most one of dma_act_o, data_in_o, unsupp_o and pio_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Soft reset or COMRESET, synchronous |
| feat_wr_i | input | 1 | Strobe for a features shadow register write |
| feat_data_i | input | 8 | Features value |
| cmd_wr_i | input | 1 | Strobe for a command register write |
| cmd_data_i | input | 8 | Command opcode |
| dev_sel_i | input | DEV_W | Selected device index |
| dir_en_i | input | NUM_DEV | Per-device direction-bit enable |
| fb_read_i | input | 1 | Fallback strap: 1 assumes read, 0 flags unsupported |
| dmarq_i | input | 1 | Device DMA request, asynchronous |
| dma_act_o | output | 1 | One-cycle request to send DMA Activate |
| data_in_o | output | 1 | Level: forward device data to the host |
| unsupp_o | output | 1 | Level: DMA packet command unsupported |
| pio_o | output | 1 | Level: current packet command is PIO |

## Verification
Random commands vary the opcode, features bits 0 and 2, the selected device, the enable vector and the strap. Together these cover the five outcomes: none, PIO, write, read and unsupported. Each outcome is told apart by which output moves on the DMA request edge and by what remains after the request falls. A second DMA request after each transfer shows that the decision does not carry over. Directed cases cover a features write after the command, a second command before the request, enables that differ between devices, and soft resets both while armed and during a read.

// File: rtl/dmadir_pkg.sv
package dmadir_pkg;
  localparam logic [7:0] OP_PACKET    = 8'hA0;
  localparam int         FEAT_DMA_BIT = 0;
  localparam int         FEAT_DIR_BIT = 2;

  typedef enum logic [1:0] {
    DIR_WRITE  = 2'd0,
    DIR_READ   = 2'd1,
    DIR_UNSUPP = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2,
    ST_PIO   = 2'd3
  } st_e;
endpackage

// File: rtl/dmadir_sync.sv
module dmadir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dmadir_cmd.sv
module dmadir_cmd
  import dmadir_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               feat_wr_i,
  input  logic [7:0]         feat_data_i,
  input  logic [7:0]         cmd_data_i,
  input  logic [DEV_W-1:0]   dev_sel_i,
  input  logic [NUM_DEV-1:0] dir_en_i,
  input  logic               fb_read_i,
  output logic               is_dma_o,
  output logic               is_pio_o,
  output dir_e               dir_o
);
  logic [7:0] feat_q;
  logic [7:0] feat_eff;
  logic       dev_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         feat_q <= '0;
    else if (soft_rst_i) feat_q <= '0;
    else if (feat_wr_i)  feat_q <= feat_data_i;
  end

  // same-cycle features write is forwarded
  assign feat_eff = feat_wr_i ? feat_data_i : feat_q;

  always_comb begin
    dev_en = 1'b0;
    for (int n = 0; n < NUM_DEV; n++)
      if (int'(dev_sel_i) == n) dev_en = dir_en_i[n];
  end

  assign is_dma_o = (cmd_data_i == OP_PACKET) &&  feat_eff[FEAT_DMA_BIT];
  assign is_pio_o = (cmd_data_i == OP_PACKET) && !feat_eff[FEAT_DMA_BIT];

  always_comb begin
    if (dev_en)         dir_o = feat_eff[FEAT_DIR_BIT] ? DIR_READ : DIR_WRITE;
    else if (fb_read_i) dir_o = DIR_READ;
    else                dir_o = DIR_UNSUPP;
  end
endmodule

// File: rtl/dmadir_fsm.sv
module dmadir_fsm
  import dmadir_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic cmd_wr_i,
  input  logic is_dma_i,
  input  logic is_pio_i,
  input  dir_e dir_i,
  input  logic dmarq_lvl_i,
  input  logic dmarq_rise_i,
  output logic act_o,
  output logic rd_o,
  output logic unsupp_o,
  output logic pio_o
);
  st_e  st_q;
  dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      dir_q    <= DIR_WRITE;
      act_o    <= 1'b0;
      rd_o     <= 1'b0;
      unsupp_o <= 1'b0;
    end else if (soft_rst_i) begin
      st_q     <= ST_IDLE;
      dir_q    <= DIR_WRITE;
      act_o    <= 1'b0;
      rd_o     <= 1'b0;
      unsupp_o <= 1'b0;
    end else if (cmd_wr_i) begin
      // command write wins over a same-cycle request edge
      act_o    <= 1'b0;
      rd_o     <= 1'b0;
      unsupp_o <= 1'b0;
      dir_q    <= dir_i;
      if (is_dma_i)      st_q <= ST_ARMED;
      else if (is_pio_i) st_q <= ST_PIO;
      else               st_q <= ST_IDLE;
    end else begin
      act_o <= 1'b0;
      unique case (st_q)
        ST_ARMED: if (dmarq_rise_i) begin
          st_q     <= ST_XFER;
          act_o    <= (dir_q == DIR_WRITE);
          rd_o     <= (dir_q == DIR_READ);
          unsupp_o <= (dir_q == DIR_UNSUPP);
        end
        ST_XFER: if (!dmarq_lvl_i) begin
          st_q <= ST_IDLE;
          rd_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign pio_o = (st_q == ST_PIO);
endmodule

// File: rtl/dma_dir_resolver.sv
module dma_dir_resolver
  import dmadir_pkg::*;
#(
  parameter int NUM_DEV     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               feat_wr_i,
  input  logic [7:0]         feat_data_i,
  input  logic               cmd_wr_i,
  input  logic [7:0]         cmd_data_i,
  input  logic [DEV_W-1:0]   dev_sel_i,
  input  logic [NUM_DEV-1:0] dir_en_i,
  input  logic               fb_read_i,
  input  logic               dmarq_i,
  output logic               dma_act_o,
  output logic               data_in_o,
  output logic               unsupp_o,
  output logic               pio_o
);
  logic dmarq_lvl, dmarq_rise;
  logic is_dma, is_pio;
  dir_e dir_res;

  dmadir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dmarq_i),
    .lvl_o  (dmarq_lvl),
    .rise_o (dmarq_rise)
  );

  dmadir_cmd #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .feat_wr_i   (feat_wr_i),
    .feat_data_i (feat_data_i),
    .cmd_data_i  (cmd_data_i),
    .dev_sel_i   (dev_sel_i),
    .dir_en_i    (dir_en_i),
    .fb_read_i   (fb_read_i),
    .is_dma_o    (is_dma),
    .is_pio_o    (is_pio),
    .dir_o       (dir_res)
  );

  dmadir_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .cmd_wr_i     (cmd_wr_i),
    .is_dma_i     (is_dma),
    .is_pio_i     (is_pio),
    .dir_i        (dir_res),
    .dmarq_lvl_i  (dmarq_lvl),
    .dmarq_rise_i (dmarq_rise),
    .act_o        (dma_act_o),
    .rd_o         (data_in_o),
    .unsupp_o     (unsupp_o),
    .pio_o        (pio_o)
  );
endmodule

// File: rtl/dmadir_chk.sv
module dmadir_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic cmd_wr_i,
  input logic dmarq_lvl,
  input logic dmarq_rise,
  input logic dma_act_o,
  input logic data_in_o,
  input logic unsupp_o,
  input logic pio_o
);
  // R4
  act_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_act_o |=> !dma_act_o);
  // R4
  act_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_act_o |-> $past(dmarq_rise));
  // R5
  rd_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_in_o) |-> $past(dmarq_rise));
  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_in_o) |-> ($past(!dmarq_lvl) || $past(cmd_wr_i) || $past(soft_rst_i)));
  // R6
  unsupp_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unsupp_o) |-> $past(dmarq_rise));
  // R3
  pio_on_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pio_o) |-> $past(cmd_wr_i));
  // R1
  soft_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !(dma_act_o || data_in_o || unsupp_o || pio_o));
  // R10
  one_hot_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_act_o, data_in_o, unsupp_o, pio_o}));
endmodule

bind dma_dir_resolver dmadir_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .cmd_wr_i   (cmd_wr_i),
  .dmarq_lvl  (dmarq_lvl),
  .dmarq_rise (dmarq_rise),
  .dma_act_o  (dma_act_o),
  .data_in_o  (data_in_o),
  .unsupp_o   (unsupp_o),
  .pio_o      (pio_o)
);

// File: tb/dma_dir_resolver_tb.sv
module dma_dir_resolver_tb;
  localparam int NUM_DEV = 2;
  localparam int SYNC    = 2;
  localparam int C_NONE = 0, C_PIO = 1, C_WR = 2, C_RD = 3, C_UNS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       feat_wr_i = 1'b0;
  logic [7:0] feat_data_i = '0;
  logic       cmd_wr_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic [0:0] dev_sel_i = '0;
  logic [1:0] dir_en_i = '0;
  logic       fb_read_i = 1'b0;
  logic       dmarq_i = 1'b0;
  logic       dma_act_o, data_in_o, unsupp_o, pio_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dma_dir_resolver #(.NUM_DEV(NUM_DEV), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i, .rst_ni, .soft_rst_i, .feat_wr_i, .feat_data_i, .cmd_wr_i,
    .cmd_data_i, .dev_sel_i, .dir_en_i, .fb_read_i, .dmarq_i,
    .dma_act_o, .data_in_o, .unsupp_o, .pio_o
  );

  function automatic int exp_code(logic [7:0] op, logic [7:0] f, logic [1:0] en,
                                  logic dev, logic strap);
    if (op != 8'hA0) return C_NONE;
    if (!f[0])       return C_PIO;
    if (en[dev])     return f[2] ? C_RD : C_WR;
    return strap ? C_RD : C_UNS;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_feat(logic [7:0] v);
    @(negedge clk_i); feat_wr_i = 1'b1; feat_data_i = v;
    @(negedge clk_i); feat_wr_i = 1'b0;
  endtask

  task automatic write_cmd(logic [7:0] op, logic dev);
    @(negedge clk_i); cmd_wr_i = 1'b1; cmd_data_i = op; dev_sel_i = dev;
    @(negedge clk_i); cmd_wr_i = 1'b0;
  endtask

  task automatic pulse_soft_rst();
    @(negedge clk_i); soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
  endtask

  // raise, check on edge, check pulse end, drop, check release, then a stray request
  task automatic burst(int code, string tag);
    @(negedge clk_i); dmarq_i = 1'b1;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    chk(dma_act_o == (code == C_WR), {tag, " R4 act on edge"}, dma_act_o, code == C_WR);
    chk(data_in_o == (code == C_RD), {tag, " R5 rd on edge"}, data_in_o, code == C_RD);
    chk(unsupp_o == (code == C_UNS), {tag, " R6 unsupp on edge"}, unsupp_o, code == C_UNS);
    chk(pio_o == (code == C_PIO), {tag, " R3 pio kept"}, pio_o, code == C_PIO);
    @(negedge clk_i);
    chk(dma_act_o == 1'b0, {tag, " R4 act one cycle"}, dma_act_o, 0);
    chk(data_in_o == (code == C_RD), {tag, " R5 rd held"}, data_in_o, code == C_RD);
    dmarq_i = 1'b0;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    chk(data_in_o == 1'b0, {tag, " R5 rd released"}, data_in_o, 0);
    chk(unsupp_o == (code == C_UNS), {tag, " R6 unsupp held"}, unsupp_o, code == C_UNS);
    dmarq_i = 1'b1;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    chk(dma_act_o == 1'b0 && data_in_o == 1'b0, {tag, " R9 stray request ignored"},
        {dma_act_o, data_in_o}, 0);
    dmarq_i = 1'b0;
    repeat (SYNC + 2) @(negedge clk_i);
  endtask

  task automatic run_case(logic [7:0] f, logic [7:0] op, logic dev, logic [1:0] en,
                          logic strap, string tag);
    int code;
    dir_en_i = en; fb_read_i = strap;
    write_feat(f);
    write_cmd(op, dev);
    code = exp_code(op, f, en, dev, strap);
    chk(pio_o == (code == C_PIO), {tag, " R3 pio after cmd"}, pio_o, code == C_PIO);
    if (code == C_NONE)
      chk(!(dma_act_o | data_in_o | unsupp_o | pio_o), {tag, " R2 non-packet quiet"},
          {dma_act_o, data_in_o, unsupp_o, pio_o}, 0);
    burst(code, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!(dma_act_o | data_in_o | unsupp_o | pio_o), "R1 reset outputs",
        {dma_act_o, data_in_o, unsupp_o, pio_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed: write, read, pio, fallbacks, non-packet
    run_case(8'h01, 8'hA0, 1'b0, 2'b11, 1'b0, "dir write");
    run_case(8'h05, 8'hA0, 1'b0, 2'b11, 1'b0, "dir read");
    run_case(8'h04, 8'hA0, 1'b0, 2'b11, 1'b0, "dir pio");
    run_case(8'h01, 8'hA0, 1'b0, 2'b00, 1'b1, "dir R6 strap read");
    run_case(8'h05, 8'hA0, 1'b0, 2'b00, 1'b0, "dir R6 strap unsupp");
    run_case(8'h05, 8'hEC, 1'b0, 2'b11, 1'b0, "dir R2 other opcode");
    // R7 per-device enable
    run_case(8'h05, 8'hA0, 1'b1, 2'b10, 1'b0, "dir R7 dev1 enabled");
    run_case(8'h05, 8'hA0, 1'b0, 2'b10, 1'b0, "dir R7 dev0 disabled");

    // R8 features write after command does not change direction
    dir_en_i = 2'b11;
    write_feat(8'h05); write_cmd(8'hA0, 1'b0); write_feat(8'h01);
    burst(C_RD, "dir R8 frozen");
    // R8 second command relatches
    write_feat(8'h05); write_cmd(8'hA0, 1'b0);
    write_feat(8'h01); write_cmd(8'hA0, 1'b0);
    burst(C_WR, "dir R8 relatch");

    // R1 soft reset while armed
    write_feat(8'h05); write_cmd(8'hA0, 1'b0);
    pulse_soft_rst();
    burst(C_NONE, "dir R1 soft reset armed");

    // R1 soft reset during read transfer
    write_feat(8'h05); write_cmd(8'hA0, 1'b0);
    @(negedge clk_i); dmarq_i = 1'b1;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    chk(data_in_o == 1'b1, "R5 rd before soft reset", data_in_o, 1);
    soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
    chk(data_in_o == 1'b0, "R1 soft reset clears rd in one clock", data_in_o, 0);
    dmarq_i = 1'b0;
    repeat (SYNC + 2) @(negedge clk_i);

    // R1 soft reset clears pio
    write_feat(8'h00); write_cmd(8'hA0, 1'b0);
    pulse_soft_rst();
    chk(pio_o == 1'b0, "R1 soft reset clears pio", pio_o, 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [7:0] f, op;
      f  = 8'($urandom);
      op = ($urandom % 4 != 0) ? 8'hA0 : 8'($urandom % 160);
      run_case(f, op, 1'($urandom), 2'($urandom), 1'($urandom), "rnd");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule